// File: doc/BRIEF.md
# Wait-State Register Bank with Error Responses (APB Subordinate)

This block is an APB subordinate that holds a small bank of 32-bit registers. A manager reaches it through the standard APB signals. Some words of the map can be written and read. Some words can only be read and return fixed identification values. Every other address is unmapped.

Each transfer is stretched by a programmable number of wait states. During the access phase the block holds PREADY low for as many cycles as the wait count of the addressed region, then completes on exactly one edge. The wait count comes from one of two 4-bit configuration inputs. One input covers the writable region. The other covers the rest of the map: the read-only words and all unmapped or misaligned addresses.

An illegal access still completes on time, with PSLVERR raised on the completing edge. An illegal access is a write to a read-only word, or any access to an unmapped or misaligned address. A faulted write or a stalled write never changes any register.

Control is a three-state machine:
- `ST_IDLE` waits for a setup cycle, where PSEL is high and PENABLE is low. It then moves to `ST_WAIT` if the selected wait count is non-zero, and to `ST_LAST` if it is zero.
- `ST_WAIT` counts down one wait per cycle. When one wait remains it moves to `ST_LAST`. If PSEL drops it returns to `ST_IDLE`.
- `ST_LAST` is the single completing cycle, with PREADY high. It always returns to `ST_IDLE`.

Top module: `apb_regbank_wait`

## Requirements
- R1: After the active-low reset `rst_n`, PREADY and PSLVERR are low and every writable register reads back as zero.
- R2: With a wait count of zero, PREADY is high in the first access cycle.
- R3: With a wait count of N, PREADY is low for N access cycles and high on access cycle N+1. N is taken at the setup cycle from `cfg_wait_rw` for writable words and from `cfg_wait_other` for every other address.
- R4: A writable register changes only on the completing edge of a write, where PSEL, PENABLE, PWRITE and PREADY are all high. It takes the PWDATA value present on that edge, and it keeps its old value through the wait cycles.
- R5: A read of a writable word returns the stored value on PRDATA during the completing cycle, with PSLVERR low.
- R6: Word index k of the read-only region reads as `{16'hA5C3, 16'(k)}` with PSLVERR low. The index is byte address bits [11:2], and the region is word indices 4 and 5, at byte addresses 0x10 and 0x14. A write to a read-only word completes with PSLVERR high and changes nothing.
- R7: An access to an unmapped word, or to an address whose bits [1:0] are non-zero, completes with PSLVERR high. A read of such an address returns zero, and a write to it modifies no register. Word indices 0 to 3, at byte addresses 0x0 to 0xC, are the writable words.
- R8: PSLVERR is high only in the completing cycle and is low in all other cycles.
- R9: PREADY is high for exactly one cycle per transfer, and back-to-back transfers each complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| cfg_wait_rw | input | 4 | Wait states for the writable region |
| cfg_wait_other | input | 4 | Wait states for the read-only region and unmapped addresses |
| pready | output | 1 | Transfer completes in this cycle |
| pslverr | output | 1 | Error response, valid only when pready is high |
| prdata | output | 32 | Read data, valid when pready is high |

## Verification
The bench drives a seeded random mix of transfers:
- writes and reads to writable, read-only, unmapped and misaligned addresses;
- wait counts that change between transfers.

This mix separates decoding into the two wait regions from decoding into the error classes. A reference model predicts each read and each error, so a write that leaked from an error or a wait cycle shows up as a read-back mismatch. Directed cases cover:
- zero waits and the maximum of 15 waits, which tell the counter's end points apart;
- PWDATA altered during wait cycles, which shows whether the capture happens on a wait cycle or on the completing edge;
- back-to-back transfers with no idle cycle between them.

// File: rtl/apb_rw_pkg.sv
package apb_rw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_LAST   = 2'd2
    } acc_state_t;

    localparam logic [15:0] RO_TAG = 16'hA5C3;

    // Identification value returned by read-only word k
    function automatic logic [31:0] ro_value(input int unsigned k);
        return {RO_TAG, 16'(k)};
    endfunction

endpackage

// File: rtl/apb_rw_decode.sv
module apb_rw_decode #(
    parameter int ADDR_W = 12,
    parameter int NUM_RW = 4,
    parameter int NUM_RO = 2,
    parameter int WAIT_W = 4,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WAIT_W-1:0] wait_rw,
    input  logic [WAIT_W-1:0] wait_other,
    output logic [IDX_W-1:0]  idx,
    output logic              hit_rw,
    output logic              hit_ro,
    output logic [WAIT_W-1:0] wait_sel
);
    localparam logic [IDX_W-1:0] RW_END = IDX_W'(NUM_RW);
    localparam logic [IDX_W-1:0] RO_END = IDX_W'(NUM_RW + NUM_RO);

    logic aligned;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        idx      = addr[ADDR_W-1:2];
        hit_rw   = aligned && (idx < RW_END);
        hit_ro   = aligned && (idx >= RW_END) && (idx < RO_END);
        wait_sel = hit_rw ? wait_rw : wait_other;
    end

    always_comb begin
        assert (!(hit_rw && hit_ro)) else $error("p_region_excl_r7");
    end
endmodule

// File: rtl/apb_rw_waitfsm.sv
module apb_rw_waitfsm
    import apb_rw_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic [WAIT_W-1:0] wait_sel,
    output logic              ready
);
    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    acc_state_t        state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (psel && !penable) begin
                    cnt_d   = wait_sel;
                    state_d = (wait_sel == '0) ? ST_LAST : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!psel) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - ONE;
                    if (cnt_q == ONE) state_d = ST_LAST;
                end
            end
            ST_LAST: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready = (state_q == ST_LAST);
    end

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    p_ready_in_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (psel && penable));
    p_wait_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && psel && cnt_q > ONE) |=> (state_q == ST_WAIT && !ready));
endmodule

// File: rtl/apb_rw_regfile.sv
module apb_rw_regfile
    import apb_rw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_RW = 4,
    parameter int NUM_RO = 2,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [NUM_RW];

    for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                store_q[i] <= '0;
            else if (wr_en && idx == IDX_W'(i))        store_q[i] <= wdata;
        end

        p_commit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (store_q[i] != $past(store_q[i])) |-> $past(wr_en && idx == IDX_W'(i)));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_RW; i++)
            if (idx == IDX_W'(i)) rdata = store_q[i];
        for (int k = 0; k < NUM_RO; k++)
            if (idx == IDX_W'(NUM_RW + k)) rdata = DATA_W'(ro_value(k));
    end
endmodule

// File: rtl/apb_regbank_wait.sv
module apb_regbank_wait #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NUM_RW = 4,
    parameter int NUM_RO = 2,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [WAIT_W-1:0] cfg_wait_rw,
    input  logic [WAIT_W-1:0] cfg_wait_other,
    output logic              pready,
    output logic              pslverr,
    output logic [DATA_W-1:0] prdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              hit_rw, hit_ro, bad_acc, wr_en;
    logic [WAIT_W-1:0] wait_sel;
    logic [DATA_W-1:0] rd_word;

    apb_rw_decode #(
        .ADDR_W(ADDR_W), .NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .WAIT_W(WAIT_W)
    ) dec_i (
        .addr(paddr), .wait_rw(cfg_wait_rw), .wait_other(cfg_wait_other),
        .idx(idx), .hit_rw(hit_rw), .hit_ro(hit_ro), .wait_sel(wait_sel)
    );

    apb_rw_waitfsm #(.WAIT_W(WAIT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .wait_sel(wait_sel), .ready(pready)
    );

    always_comb begin
        bad_acc = pwrite ? !hit_rw : !(hit_rw || hit_ro);
        wr_en   = psel && penable && pwrite && pready && hit_rw;
        pslverr = pready && bad_acc;
        prdata  = (pready && !pwrite && !bad_acc) ? rd_word : '0;
    end

    apb_rw_regfile #(
        .DATA_W(DATA_W), .NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .IDX_W(IDX_W)
    ) rf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx),
        .wdata(pwdata), .rdata(rd_word)
    );

    p_err_on_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> pready);
    p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && pslverr) |-> !wr_en);
    p_write_only_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (pready && penable && psel));
endmodule

// File: tb/apb_regbank_wait_tb.sv
module apb_regbank_wait_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  cfg_wait_rw = '0, cfg_wait_other = '0;
    logic        pready, pslverr;
    logic [31:0] prdata;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [4];

    always #10 clk = ~clk;   // 50 MHz

    apb_regbank_wait dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .cfg_wait_rw(cfg_wait_rw),
        .cfg_wait_other(cfg_wait_other), .pready(pready), .pslverr(pslverr),
        .prdata(prdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_rw(input logic [11:0] a);
        return a[1:0] == 2'b00 && a[11:2] < 4;
    endfunction
    function automatic bit is_ro(input logic [11:0] a);
        return a[1:0] == 2'b00 && a[11:2] >= 4 && a[11:2] < 6;
    endfunction
    function automatic int exp_waits(input logic [11:0] a);
        return is_rw(a) ? int'(cfg_wait_rw) : int'(cfg_wait_other);
    endfunction
    function automatic bit exp_err(input logic [11:0] a, input bit wr);
        return wr ? !is_rw(a) : !(is_rw(a) || is_ro(a));
    endfunction
    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        if (is_rw(a)) return model[a[3:2]];
        if (is_ro(a)) return {16'hA5C3, 16'(a[11:2] - 10'd4)};
        return 32'h0;
    endfunction

    // One transfer; optionally alters pwdata during waits, optionally no idle after
    task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input bit wiggle, input bit b2b);
        int waits = 0;
        bit early_err = 0;
        int ew = exp_waits(a);
        bit ee = exp_err(a, wr);
        logic [31:0] er = exp_rd(a);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wiggle ? ~d : d;
        @(negedge clk);
        penable = 1;
        while (!pready && waits < 40) begin
            if (pslverr) early_err = 1;
            waits++;
            @(negedge clk);
            if (wiggle) pwdata = (pready) ? d : pwdata + 32'd1;
        end
        if (wiggle) pwdata = d;
        check(waits == ew, ew == 0 ? "R2 zero-wait ready" : "R3 wait count",
              32'(waits), 32'(ew));
        check(!early_err, "R8 pslverr during wait", 32'(early_err), 32'h0);
        check(pslverr == ee, ee ? "R7/R6 error response" : "R5 no error",
              32'(pslverr), 32'(ee));
        if (!wr) check(prdata == er, is_ro(a) ? "R6 ro read" : "R5/R7 read data", prdata, er);
        if (wr && !ee) model[a[3:2]] = d;
        @(negedge clk);
        check(!pready, "R9 single ready pulse", 32'(pready), 32'h0);
        if (!b2b) begin
            psel = 0; penable = 0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20ns * 150000);
        failures++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [11:0] pick [9];
        void'($urandom(32'd7341));
        pick = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018,
                 12'h100, 12'h002};
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check(!pready && !pslverr, "R1 reset outputs", {30'b0, pready, pslverr}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        // R1: writable words cleared
        for (int i = 0; i < 4; i++) xfer(0, 12'(i * 4), 0, 0, 0);
        // R2 / R4 directed: zero waits write then read
        cfg_wait_rw = 0; cfg_wait_other = 0;
        xfer(1, 12'h004, 32'hDEAD_BEEF, 0, 0);
        xfer(0, 12'h004, 0, 0, 0);
        // R3 / R4: maximum waits, data altered during waits, committed value is last
        cfg_wait_rw = 4'd15;
        xfer(1, 12'h008, 32'h1234_5678, 1, 0);
        xfer(0, 12'h008, 0, 0, 0);
        // R6: read-only words and write attempt
        cfg_wait_other = 4'd3;
        xfer(0, 12'h010, 0, 0, 0);
        xfer(1, 12'h014, 32'hFFFF_FFFF, 0, 0);
        xfer(0, 12'h014, 0, 0, 0);
        // R7: unmapped and misaligned writes leave all registers untouched
        xfer(1, 12'h100, 32'h5555_5555, 0, 0);
        xfer(1, 12'h00A, 32'h6666_6666, 0, 0);
        xfer(0, 12'h100, 0, 0, 0);
        for (int i = 0; i < 4; i++) xfer(0, 12'(i * 4), 0, 0, 0);
        // R9: back-to-back transfers
        cfg_wait_rw = 1;
        xfer(1, 12'h00C, 32'hA0A0_0001, 0, 1);
        xfer(1, 12'h000, 32'hA0A0_0002, 0, 1);
        xfer(0, 12'h00C, 0, 0, 1);
        xfer(0, 12'h000, 0, 0, 0);
        // Random mix
        for (int n = 0; n < 120; n++) begin
            cfg_wait_rw    = 4'($urandom_range(0, 6));
            cfg_wait_other = 4'($urandom_range(0, 6));
            xfer(1'($urandom_range(0, 1)), pick[$urandom_range(0, 8)], $urandom(),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
        end
        for (int i = 0; i < 4; i++) xfer(0, 12'(i * 4), 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule